// File: doc/BRIEF.md
# Load Ordering Violation Detector

This block tracks in-flight loads so that they can read the coherent cache out of order while the core still keeps load-to-load ordering under a total-store-order memory model. Loads are entered into a 16-deep circular queue in program order. Each entry is identified by its slot number. When a load reads the cache, its cache-line address is recorded against its slot. When its data is returned, the slot is marked complete. Loads leave the queue in order, and only once their data has arrived.

The coherence side reports invalidations and evictions by line address. The block assumes that a line read early by a load stays valid until all older loads have completed. That assumption fails when a notice hits the line of a completed, unretired load while some older load in the queue still lacks its data. In that case the block raises a memory-order machine clear that names the oldest such load. It frees that slot and every younger slot, and it increments a running count of these clears. Replay and re-fetch of the squashed loads are handled outside the block.

Allocation is a valid/ready stream. `alloc_tag` is valid whenever `alloc_valid` is high, and a load is entered only in a cycle in which both `alloc_valid` and `alloc_ready` are high. The producer must hold the request until it is accepted. Retirement is also a valid/ready handshake. The retire side raises `retire_valid`, and the oldest load leaves only when `retire_ready` is high. Execution reports, data reports and snoops carry no back-pressure and are always taken.

Top module: `lqo_order_guard`

## Requirements
- R1: `alloc_tag` equals the slot after the youngest occupied slot, counting upward modulo 16 in program order. `alloc_ready` is low whenever all 16 slots are occupied.
- R2: An execution report (`exec_valid`, `exec_tag`, `exec_line`) records the line address of that slot. A data report (`data_valid`, `data_tag`) marks that slot complete.
- R3: `retire_ready` is high only when the queue is non-empty and its oldest slot is complete. A retire handshake frees exactly the oldest slot.
- R4: A snoop is a violation, and `clear_valid` goes high on the next cycle, when both of these hold:
  - its line equals the recorded line of an occupied, executed, complete slot;
  - some occupied slot older than that slot had not received its data before the snoop cycle.
- R5: A snoop that hits only complete slots with no incomplete older slot raises no clear and leaves `lq_count` unchanged apart from allocation and retirement.
- R6: A slot whose data report arrives in the same cycle as a snoop to its line is treated as complete for R4.
- R7: `clear_tag` names the oldest violating slot. After the clear, that slot and all younger slots are free, so `lq_count` equals that slot's age (its distance from the oldest slot), minus one if a retire happened in the same cycle.
- R8: `mo_count` increments by one, modulo 2^16, in the same cycle that `clear_valid` is high, and holds otherwise.
- R9: After reset the queue is empty, `clear_valid` is low, `mo_count` is 0 and `alloc_ready` is high.
- R10: In a cycle in which a violation is detected, `alloc_ready` is low and no load is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | New load requests a slot |
| alloc_ready | output | 1 | Slot available and no violation this cycle |
| alloc_tag | output | 4 | Slot given to the new load |
| exec_valid | input | 1 | A load has read the cache |
| exec_tag | input | 4 | Slot of the executed load |
| exec_line | input | 26 | Line address read |
| data_valid | input | 1 | Data returned for a load |
| data_tag | input | 4 | Slot whose data returned |
| snoop_valid | input | 1 | Invalidation or eviction notice |
| snoop_line | input | 26 | Line address of the notice |
| retire_valid | input | 1 | Retire side wants the oldest load |
| retire_ready | output | 1 | Oldest load complete and may leave |
| clear_valid | output | 1 | Memory-order machine clear |
| clear_tag | output | 4 | Slot from which loads are squashed |
| lq_count | output | 5 | Number of occupied slots |
| mo_count | output | 16 | Running count of machine clears |

## Verification
`alloc_ready`, `alloc_tag` and `retire_ready` are combinational and belong to the cycle whose inputs are being driven. The bench drives each cycle at the falling edge and compares those outputs one nanosecond later. `clear_valid`, `clear_tag`, `lq_count` and `mo_count` pass through one register stage and reflect a snoop, allocation or retire one rising edge later. They are therefore compared one nanosecond after that rising edge, against a model that is updated at the same point. The model derives the expected violation and target from the slot states before the edge. It counts a data report arriving in the same cycle as complete.

// File: rtl/lqo_pkg.sv
package lqo_pkg;
  localparam int unsigned LQ_DEPTH_DFLT = 16;
  localparam int unsigned LINE_W_DFLT   = 26;
  localparam int unsigned CNT_W_DFLT    = 16;
endpackage

// File: rtl/lqo_entry_bank.sv
module lqo_entry_bank #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LINE_W = 26,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_fire,
  input  logic [AW-1:0]     alloc_idx,
  input  logic              exec_fire,
  input  logic [AW-1:0]     exec_idx,
  input  logic [LINE_W-1:0] exec_line,
  input  logic              data_fire,
  input  logic [AW-1:0]     data_idx,
  output logic [LINE_W-1:0] line_q [DEPTH],
  output logic [DEPTH-1:0]  exec_q,
  output logic [DEPTH-1:0]  done_q,
  output logic [DEPTH-1:0]  done_now
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_alloc, hit_exec, hit_data;
    assign hit_alloc = alloc_fire && (alloc_idx == AW'(g));
    assign hit_exec  = exec_fire  && (exec_idx  == AW'(g));
    assign hit_data  = data_fire  && (data_idx  == AW'(g));
    assign done_now[g] = done_q[g] | hit_data;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        exec_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
        line_q[g] <= '0;
      end else if (hit_alloc) begin
        exec_q[g] <= 1'b0;
        done_q[g] <= 1'b0;
      end else begin
        if (hit_exec) begin
          exec_q[g] <= 1'b1;
          line_q[g] <= exec_line;
        end
        if (hit_data) done_q[g] <= 1'b1;
      end
    end
  end

  // R2: data may only be reported for a slot whose cache read was recorded
  p_data_after_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_fire |-> exec_q[data_idx]);
endmodule

// File: rtl/lqo_age_scan.sv
module lqo_age_scan #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned LINE_W = 26,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic [AW-1:0]     head_idx,
  input  logic [AW:0]       occupancy,
  input  logic              snoop_valid,
  input  logic [LINE_W-1:0] snoop_line,
  input  logic [LINE_W-1:0] line_q [DEPTH],
  input  logic [DEPTH-1:0]  exec_q,
  input  logic [DEPTH-1:0]  done_q,
  input  logic [DEPTH-1:0]  done_now,
  output logic              viol,
  output logic [AW-1:0]     target_age,
  output logic [AW-1:0]     target_idx
);
  always_comb begin
    logic          older_open;
    logic [AW-1:0] idx;
    older_open = 1'b0;
    viol       = 1'b0;
    target_age = '0;
    target_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head_idx + AW'(k);
      if ((AW+1)'(k) < occupancy) begin
        if (snoop_valid && !viol && older_open && exec_q[idx] &&
            done_now[idx] && (line_q[idx] == snoop_line)) begin
          viol       = 1'b1;
          target_age = AW'(k);
          target_idx = idx;
        end
        if (!done_q[idx]) older_open = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lqo_event_ctr.sv
module lqo_event_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (bump) value <= value + CNT_W'(1);
  end
endmodule

// File: rtl/lqo_order_guard.sv
module lqo_order_guard
  import lqo_pkg::*;
#(
  parameter int unsigned DEPTH  = LQ_DEPTH_DFLT,
  parameter int unsigned LINE_W = LINE_W_DFLT,
  parameter int unsigned CNT_W  = CNT_W_DFLT,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [AW-1:0]     alloc_tag,
  input  logic              exec_valid,
  input  logic [AW-1:0]     exec_tag,
  input  logic [LINE_W-1:0] exec_line,
  input  logic              data_valid,
  input  logic [AW-1:0]     data_tag,
  input  logic              snoop_valid,
  input  logic [LINE_W-1:0] snoop_line,
  input  logic              retire_valid,
  output logic              retire_ready,
  output logic              clear_valid,
  output logic [AW-1:0]     clear_tag,
  output logic [AW:0]       lq_count,
  output logic [CNT_W-1:0]  mo_count
);
  logic [AW:0]       head_q, tail_q;
  logic [LINE_W-1:0] line_q [DEPTH];
  logic [DEPTH-1:0]  exec_q, done_q, done_now;
  logic              viol;
  logic [AW-1:0]     target_age, target_idx;
  logic              alloc_fire, retire_fire;

  assign lq_count     = tail_q - head_q;
  assign alloc_tag    = tail_q[AW-1:0];
  assign alloc_ready  = (lq_count != (AW+1)'(DEPTH)) && !viol;
  assign alloc_fire   = alloc_valid && alloc_ready;
  assign retire_ready = (lq_count != '0) && done_q[head_q[AW-1:0]];
  assign retire_fire  = retire_valid && retire_ready;

  lqo_entry_bank #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_bank (
    .clk, .rst_n,
    .alloc_fire, .alloc_idx(tail_q[AW-1:0]),
    .exec_fire(exec_valid), .exec_idx(exec_tag), .exec_line,
    .data_fire(data_valid), .data_idx(data_tag),
    .line_q, .exec_q, .done_q, .done_now
  );

  lqo_age_scan #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_scan (
    .head_idx(head_q[AW-1:0]), .occupancy(lq_count),
    .snoop_valid, .snoop_line,
    .line_q, .exec_q, .done_q, .done_now,
    .viol, .target_age, .target_idx
  );

  lqo_event_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk, .rst_n, .bump(viol), .value(mo_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q      <= '0;
      tail_q      <= '0;
      clear_valid <= 1'b0;
      clear_tag   <= '0;
    end else begin
      if (viol)            tail_q <= head_q + {1'b0, target_age};
      else if (alloc_fire) tail_q <= tail_q + 1'b1;
      if (retire_fire)     head_q <= head_q + 1'b1;
      clear_valid <= viol;
      if (viol) clear_tag <= target_idx;
    end
  end

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    lq_count <= (AW+1)'(DEPTH));
  p_retire_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retire_ready |-> (lq_count != '0));
  p_retire_needs_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retire_fire |=> $past(done_q[head_q[AW-1:0]]));
  p_clear_shrinks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (lq_count < $past(lq_count)));
  p_clear_counted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_valid |-> (mo_count == CNT_W'($past(mo_count) + 1'b1)));
  p_no_clear_no_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_valid |-> $stable(mo_count));
endmodule

// File: tb/tb_lqo_order_guard.sv
module tb_lqo_order_guard;
  localparam int N = 16;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic alloc_valid, alloc_ready, exec_valid, data_valid, snoop_valid;
  logic retire_valid, retire_ready, clear_valid;
  logic [3:0] alloc_tag, exec_tag, data_tag, clear_tag;
  logic [25:0] exec_line, snoop_line;
  logic [4:0] lq_count;
  logic [15:0] mo_count;

  lqo_order_guard dut (.*);

  int checks = 0, errors = 0;
  bit m_exec[N], m_done[N];
  int m_line[N];
  int m_head, m_tail, m_cnt;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void scan(input bit sv, input int sl, input bit dv,
                               input int dt, output bit v, output int tage);
    bit seen;
    seen = 0; v = 0; tage = 0;
    for (int k = 0; k < m_tail - m_head; k++) begin
      int i;
      bit dn;
      i  = (m_head + k) % N;
      dn = m_done[i] || (dv && dt == i);
      if (sv && !v && seen && m_exec[i] && dn && m_line[i] == sl) begin
        v = 1; tage = k;
      end
      if (!m_done[i]) seen = 1;
    end
  endfunction

  task automatic cyc(bit av, bit ev, int et, int el, bit dv, int dt,
                     bit sv, int sl, bit rv);
    bit v, ear, err;
    int tage, occ, h0;
    @(negedge clk);
    alloc_valid = av; exec_valid = ev; exec_tag = 4'(et); exec_line = 26'(el);
    data_valid = dv; data_tag = 4'(dt); snoop_valid = sv; snoop_line = 26'(sl);
    retire_valid = rv;
    #1;
    occ = m_tail - m_head;
    scan(sv, sl, dv, dt, v, tage);
    ear = (occ < N) && !v;
    err = (occ > 0) && m_done[m_head % N];
    chk(alloc_ready == ear, "R1 R10 alloc_ready", alloc_ready, ear);
    chk(alloc_tag == 4'(m_tail % N), "R1 alloc_tag", alloc_tag, m_tail % N);
    chk(retire_ready == err, "R2 R3 retire_ready", retire_ready, err);
    @(posedge clk); #1;
    h0 = m_head;
    if (v) m_tail = m_head + tage;
    else if (av && ear) begin
      m_exec[m_tail % N] = 0; m_done[m_tail % N] = 0; m_tail++;
    end
    if (ev) begin m_exec[et] = 1; m_line[et] = el; end
    if (dv) m_done[dt] = 1;
    if (rv && err) m_head++;
    if (v) m_cnt = (m_cnt + 1) & 16'hFFFF;
    chk(clear_valid == v, "R4 R5 R6 clear_valid", clear_valid, v);
    if (v) chk(clear_tag == 4'((h0 + tage) % N), "R7 clear_tag", clear_tag, (h0 + tage) % N);
    chk(lq_count == 5'(m_tail - m_head), "R7 lq_count", lq_count, m_tail - m_head);
    chk(mo_count == 16'(m_cnt), "R8 mo_count", mo_count, m_cnt);
  endtask

  task automatic idle(); cyc(0,0,0,0,0,0,0,0,0); endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    alloc_valid = 0; exec_valid = 0; data_valid = 0; snoop_valid = 0; retire_valid = 0;
    exec_tag = 0; exec_line = 0; data_tag = 0; snoop_line = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_head = 0; m_tail = 0; m_cnt = 0;
    for (int i = 0; i < N; i++) begin m_exec[i] = 0; m_done[i] = 0; m_line[i] = 0; end
    #1;
    chk(alloc_ready == 1, "R9 alloc_ready", alloc_ready, 1);
    chk(retire_ready == 0, "R9 retire_ready", retire_ready, 0);
    chk(clear_valid == 0, "R9 clear_valid", clear_valid, 0);
    chk(lq_count == 0, "R9 lq_count", lq_count, 0);
    chk(mo_count == 0, "R9 mo_count", mo_count, 0);
  endtask

  task automatic rand_cycle();
    int occ, k, i, et, el, dt;
    bit ev, dv;
    occ = m_tail - m_head;
    ev = 0; dv = 0; et = 0; dt = 0; el = 0;
    if (occ > 0) begin
      k = $urandom % occ; i = (m_head + k) % N;
      if (!m_exec[i]) begin ev = 1; et = i; el = $urandom % 4; end
      k = $urandom % occ; i = (m_head + k) % N;
      if (m_exec[i] && !m_done[i] && !(ev && et == i) && ($urandom % 3 == 0)) begin
        dv = 1; dt = i;
      end
    end
    cyc(bit'($urandom % 2), ev, et, el, dv, dt,
        bit'($urandom % 3 == 0), $urandom % 4, bit'($urandom % 2));
  endtask

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R4/R7: slot 1 complete on line 5 while slot 0 is still waiting
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(1,1,0,7,0,0,0,0,0);
    cyc(1,1,1,5,0,0,0,0,0);
    cyc(0,0,0,0,1,1,0,0,1);   // R3: head lacks data, no retire
    cyc(0,0,0,0,0,0,1,5,0);
    chk(clear_valid == 1 && clear_tag == 1, "R4 directed clear", clear_tag, 1);
    chk(lq_count == 1, "R7 directed squash", lq_count, 1);
    // R5: no older incomplete load
    cyc(0,0,0,0,1,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(0,1,1,9,0,0,0,0,0);
    cyc(0,0,0,0,1,1,0,0,0);
    cyc(0,0,0,0,0,0,1,9,0);
    chk(clear_valid == 0 && lq_count == 2, "R5 directed no clear", lq_count, 2);
    cyc(0,0,0,0,0,0,0,0,1);
    cyc(0,0,0,0,0,0,0,0,1);
    // R6: data and snoop in the same cycle
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(1,0,0,0,0,0,0,0,0);
    cyc(0,1,3,4,0,0,0,0,0);
    cyc(0,1,2,8,0,0,0,0,0);
    cyc(0,0,0,0,1,3,1,4,0);
    chk(clear_valid == 1 && clear_tag == 3, "R6 same-cycle data", clear_tag, 3);
    // R1: fill all slots
    for (int j = 0; j < 20; j++) cyc(1,0,0,0,0,0,0,0,0);
    chk(lq_count == 16 && alloc_ready == 0, "R1 full queue", lq_count, 16);
    do_reset();
    for (int j = 0; j < 4000; j++) rand_cycle();
    idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule